// File: doc/BRIEF.md
# Power-on delayed reset sequencer

This block turns power-up into one clean, active-low reset for a processor. It needs no reset input of its own: every flip-flop wakes at zero. A delay counter advances while the clock-lock qualifier is high and wraps at a fixed terminal count. The first wrap sets a flag that stays set, and the rising edge of that flag becomes a single-cycle pulse. A stretcher widens the pulse into a low window of fixed length on the reset output.

Later counter wraps leave the reset output untouched, so the processor is reset exactly once. The delay is measured in enabled clocks. A parameter chooses whether the lock qualifier gates the counter or is ignored. The terminal count can be raised for hardware builds that need a longer start-up delay.

Top module: `por_reset_seq`

## Requirements
- R1: After power-up, with no external reset applied, `rst_no` reads 1 before the first clock edge and for every cycle before the reset window.
- R2: With the lock qualifier in use (`USE_LOCK`=1), the delay counter holds its value on any clock edge where `lock_i` is 0, so the reset window moves later by exactly the number of such edges.
- R3: The delay counter counts up by one from 0 on each enabled edge. Its wrap indication is raised while the count equals `TERM_CNT`-1 (default 249). The count returns to 0 on the next enabled edge, which gives a period of `TERM_CNT` (default 250) enabled edges.
- R4: The first wrap arms a sticky flag that never clears. Later wraps produce no further reset, so across several counter periods `rst_no` falls exactly once.
- R5: The flag's 0-to-1 transition produces a pulse exactly one clock wide, registered on the rising clock edge.
- R6: `rst_no` is 0 for exactly `PULSE_LEN` (default 5) consecutive cycles. The window starts right after enabled edge number `TERM_CNT`+2, counted from power-up, when `lock_i` stays high from the wrap onward.
- R7: Outside that window `rst_no` is 1, both during the start-up delay and after the window, including across every later wrap.
- R8: If `lock_i` is 0 while the count sits at `TERM_CNT`-1, no wrap is taken and `rst_no` stays 1. The wrap happens on the first edge where `lock_i` is high again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| lock_i | input | 1 | Clock-lock qualifier; enables the delay counter when `USE_LOCK`=1 |
| rst_no | output | 1 | Active-low processor reset; one low window after power-up |

## Verification
Two functions can meet on one edge: the counter reaching its terminal value and the lock qualifier dropping. If the wrap were not gated by the enable, the reset would fire early. The bench provokes this by pulling `lock_i` low for several cycles exactly when the counter holds 249. It also drops the qualifier for a longer stretch in the middle of the count. It tracks enabled edges arithmetically, predicts on every cycle whether `rst_no` must be low, and confirms that exactly one five-cycle window appears over five counter periods.

// File: rtl/por_seq_pkg.sv
package por_seq_pkg;
  localparam int unsigned DEF_CNT_W     = 20;
  localparam int unsigned DEF_TERM_CNT  = 250;
  localparam int unsigned DEF_PULSE_LEN = 5;
endpackage

// File: rtl/por_delay_cnt.sv
module por_delay_cnt #(
  parameter int unsigned CNT_W    = por_seq_pkg::DEF_CNT_W,
  parameter int unsigned TERM_CNT = por_seq_pkg::DEF_TERM_CNT
) (
  input  logic             clk_i,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TERM_CNT - 1);

  logic [CNT_W-1:0] cnt_q = '0;
  logic             at_last;

  assign at_last = (cnt_q == LAST);
  assign wrap_o  = en_i && at_last;
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i) begin
    if (en_i) begin
      if (at_last) cnt_q <= '0;
      else         cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/por_first_latch.sv
module por_first_latch (
  input  logic clk_i,
  input  logic set_i,
  output logic flag_o
);
  logic flag_q = 1'b0;

  always_ff @(posedge clk_i) begin
    if (set_i) flag_q <= 1'b1;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/por_rise_pulse.sv
module por_rise_pulse (
  input  logic clk_i,
  input  logic lvl_i,
  output logic pulse_o
);
  logic prev_q  = 1'b0;
  logic pulse_q = 1'b0;

  always_ff @(posedge clk_i) begin
    prev_q  <= lvl_i;
    pulse_q <= lvl_i && !prev_q;
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/por_low_stretch.sv
module por_low_stretch #(
  parameter int unsigned PULSE_LEN = por_seq_pkg::DEF_PULSE_LEN
) (
  input  logic clk_i,
  input  logic trig_i,
  output logic rst_no
);
  localparam int unsigned SW = $clog2(PULSE_LEN + 1);
  localparam logic [SW-1:0] LOAD = SW'(PULSE_LEN);

  logic [SW-1:0] left_q = '0;

  always_ff @(posedge clk_i) begin
    if (trig_i)              left_q <= LOAD;
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign rst_no = (left_q == '0);
endmodule

// File: rtl/por_reset_seq.sv
module por_reset_seq #(
  parameter int unsigned CNT_W     = por_seq_pkg::DEF_CNT_W,
  parameter int unsigned TERM_CNT  = por_seq_pkg::DEF_TERM_CNT,
  parameter int unsigned PULSE_LEN = por_seq_pkg::DEF_PULSE_LEN,
  parameter bit          USE_LOCK  = 1'b1
) (
  input  logic clk_i,
  input  logic lock_i,
  output logic rst_no
);
  logic             cnt_en;
  logic [CNT_W-1:0] cnt_w;
  logic             wrap_w;
  logic             armed_w;
  logic             pulse_w;

  generate
    if (USE_LOCK) begin : g_lock
      assign cnt_en = lock_i;
    end else begin : g_free
      assign cnt_en = 1'b1;
    end
  endgenerate

  por_delay_cnt #(.CNT_W(CNT_W), .TERM_CNT(TERM_CNT)) u_cnt (
    .clk_i (clk_i),
    .en_i  (cnt_en),
    .cnt_o (cnt_w),
    .wrap_o(wrap_w)
  );

  por_first_latch u_arm (
    .clk_i (clk_i),
    .set_i (wrap_w),
    .flag_o(armed_w)
  );

  por_rise_pulse u_edge (
    .clk_i  (clk_i),
    .lvl_i  (armed_w),
    .pulse_o(pulse_w)
  );

  por_low_stretch #(.PULSE_LEN(PULSE_LEN)) u_str (
    .clk_i (clk_i),
    .trig_i(pulse_w),
    .rst_no(rst_no)
  );
endmodule

// File: rtl/por_reset_seq_chk.sv
module por_reset_seq_chk #(
  parameter int unsigned CNT_W     = 20,
  parameter int unsigned TERM_CNT  = 250,
  parameter int unsigned PULSE_LEN = 5,
  parameter bit          USE_LOCK  = 1'b1
) (
  input logic             clk_i,
  input logic             lock_i,
  input logic             rst_no,
  input logic [CNT_W-1:0] cnt_w,
  input logic             wrap_w,
  input logic             armed_w,
  input logic             pulse_w
);
  logic        live_q   = 1'b0;
  logic        fell_q   = 1'b0;
  logic [31:0] low_run  = '0;
  logic        en;

  assign en = USE_LOCK ? lock_i : 1'b1;

  always_ff @(posedge clk_i) begin
    live_q  <= 1'b1;
    if (live_q && !rst_no) low_run <= low_run + 1;
    else                   low_run <= '0;
    if (live_q && !rst_no) fell_q <= 1'b1;
  end

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!live_q)
    !en |=> $stable(cnt_w));
  a_r3_step: assert property (@(posedge clk_i) disable iff (!live_q)
    (en && !wrap_w) |=> (cnt_w == $past(cnt_w) + 1'b1));
  a_r3_wrap: assert property (@(posedge clk_i) disable iff (!live_q)
    wrap_w |=> (cnt_w == '0));
  a_r4_sticky: assert property (@(posedge clk_i) disable iff (!live_q)
    armed_w |=> armed_w);
  a_r4_once: assert property (@(posedge clk_i) disable iff (!live_q)
    $fell(rst_no) |-> !$past(fell_q));
  a_r5_pulse: assert property (@(posedge clk_i) disable iff (!live_q)
    $rose(armed_w) |=> pulse_w);
  a_r5_narrow: assert property (@(posedge clk_i) disable iff (!live_q)
    pulse_w |=> !pulse_w);
  a_r6_len: assert property (@(posedge clk_i) disable iff (!live_q)
    $rose(rst_no) |-> (low_run == PULSE_LEN));
  a_r6_max: assert property (@(posedge clk_i) disable iff (!live_q)
    low_run <= PULSE_LEN);
  a_r7_armed: assert property (@(posedge clk_i) disable iff (!live_q)
    !rst_no |-> armed_w);
endmodule

bind por_reset_seq por_reset_seq_chk #(
  .CNT_W(CNT_W), .TERM_CNT(TERM_CNT), .PULSE_LEN(PULSE_LEN), .USE_LOCK(USE_LOCK)
) u_chk (
  .clk_i  (clk_i),
  .lock_i (lock_i),
  .rst_no (rst_no),
  .cnt_w  (cnt_w),
  .wrap_w (wrap_w),
  .armed_w(armed_w),
  .pulse_w(pulse_w)
);

// File: tb/tb_por_reset_seq.sv
`timescale 1ns/1ps
module tb_por_reset_seq;
  localparam int TERM  = 250;
  localparam int PLEN  = 5;
  localparam int FIRST = TERM + 2;

  logic clk = 1'b0;
  logic lock_i = 1'b0;
  logic rst_no;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  por_reset_seq #(.CNT_W(20), .TERM_CNT(TERM), .PULSE_LEN(PLEN), .USE_LOCK(1'b1)) dut (
    .clk_i (clk),
    .lock_i(lock_i),
    .rst_no(rst_no)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    int en_cnt = 0;
    int hold_a = 0;
    int hold_b = 0;
    int falls  = 0;
    int lows   = 0;
    int start  = -1;
    bit prev   = 1'b1;
    bit exp_hi;
    string tag;

    #1;
    chk(rst_no === 1'b1, "R1", rst_no, 1);
    for (int cyc = 0; cyc < 3000 && en_cnt < TERM * 5 + 10; cyc++) begin
      @(negedge clk);
      exp_hi = !(en_cnt >= FIRST && en_cnt < FIRST + PLEN);
      if (!exp_hi)                    tag = "R6";
      else if (en_cnt == 100)         tag = "R2";
      else if (en_cnt == TERM - 1)    tag = "R8";
      else if (en_cnt < FIRST)        tag = "R1";
      else                            tag = "R7";
      chk(rst_no === exp_hi, tag, rst_no, exp_hi);
      if (prev && !rst_no) begin
        falls++;
        if (start < 0) start = en_cnt;
      end
      if (!rst_no) lows++;
      prev = rst_no;
      if (cyc < 7) lock_i = 1'b0;
      else if (en_cnt == 100 && hold_a < 20) begin lock_i = 1'b0; hold_a++; end
      else if (en_cnt == TERM - 1 && hold_b < 9) begin lock_i = 1'b0; hold_b++; end
      else lock_i = 1'b1;
      @(posedge clk);
      if (lock_i) en_cnt++;
    end
    chk(falls == 1, "R4", falls, 1);
    chk(lows == PLEN, "R6", lows, PLEN);
    chk(start == FIRST, "R3", start, FIRST);
    chk(hold_b == 9, "R8", hold_b, 9);
    chk(hold_a == 20, "R2", hold_a, 20);
    chk(en_cnt >= TERM * 5, "R5", en_cnt, TERM * 5);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule